// File: doc/BRIEF.md
# Speculative Load-Store Ordering Checker

This block sits beside a load/store scheduler and rules, cycle by cycle, whether a load may start before stores that come earlier in program order. It keeps a small queue of in-flight stores, each tagged with a wrap-around sequence number and an address that arrives later from address generation. A table of 2-bit confidence counters, selected by the low bits of the load's program counter, decides whether a load may pass earlier stores whose addresses are still unknown.

Loads that start are remembered until they retire. When a store address arrives, the block compares it against every remembered load that is younger than that store. A match means the earlier guess was wrong. The block then reports the oldest offending load for re-execution, raises its stall output for a fixed 20 cycles and marks that load's counter as "will alias". Each load that retires cleanly lowers its counter by one.

Top module: `ldst_order_unit`

## Requirements
- R1: After reset, stall, replay_v and sq_full are 0, every counter reads 0 and both queues are empty, so a lone load request is granted.
- R2: A load is refused while an earlier store with a known address sits in the same 8-byte block (address bits above bit 2 equal). A known earlier store in a different block does not hold the load back.
- R3: An earlier store with an unknown address blocks a load only when the counter selected by ld_req_pc[3:0] is 2 or 3.
- R4: Stores that are younger than the load never hold it back, and their address resolution never reports that load.
- R5: When a store address resolves, each remembered load that is younger than the store and in the same 8-byte block conflicts. In the next cycle replay_v pulses for one cycle and replay_seq carries the load's sequence number. That load is forgotten.
- R6: When several loads conflict with one resolving store, only the oldest one is reported.
- R7: stall goes high in the cycle that replay_v is high and stays high for exactly 20 cycles. No load is granted while stall is high.
- R8: A replay sets the reported load's counter to 3. Each load retirement that is not a replay lowers its counter by 1, with a floor of 0.
- R9: The store queue holds 8 entries. sq_full is 1 when all 8 are occupied, and an allocation while full is dropped. A commit frees the entry whose sequence number matches.
- R10: No grant is given in a cycle in which a store address resolves, nor while all 4 load-tracker slots are in use.
- R11: Age compares 6-bit sequence numbers modulo 64: a is earlier than b when (a-b) mod 64 has its top bit set, so seq 62 is earlier than seq 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_alloc_v | input | 1 | Enter a store into the queue |
| st_alloc_seq | input | 6 | Sequence number of the new store |
| sq_full | output | 1 | All store entries occupied |
| st_res_v | input | 1 | A store address has been computed |
| st_res_seq | input | 6 | Sequence number of that store |
| st_res_addr | input | 32 | Store byte address |
| st_commit_v | input | 1 | Store leaves the queue |
| st_commit_seq | input | 6 | Sequence number of the leaving store |
| ld_req_v | input | 1 | Load asks to issue |
| ld_req_seq | input | 6 | Load sequence number |
| ld_req_pc | input | 32 | Load program counter |
| ld_req_addr | input | 32 | Load byte address |
| ld_grant | output | 1 | Load may issue this cycle (same cycle) |
| ld_retire_v | input | 1 | A tracked load retires |
| ld_retire_seq | input | 6 | Sequence number of the retiring load |
| replay_v | output | 1 | One-cycle replay request |
| replay_seq | output | 6 | Load that must re-execute |
| stall | output | 1 | Misprediction penalty window |

## Verification
The bench covers address pairs that differ only below bit 3, because a block compare that is too fine would let the load through. It covers loads that are older than an unresolved store, because a design with the age test inverted would refuse them or replay them. Two conflicting loads are entered youngest first, and the wrong load is reported if the selection follows slot order instead of age. Sequence numbers wrap from 62 to 1, which a plain magnitude compare treats as reversed order. The stall window is counted cycle by cycle. The counter is walked from 3 down to 1, and a dropped allocation is checked by watching whether a phantom unresolved store still blocks a high-counter load.

// File: rtl/ldst_order_pkg.sv
package ldst_order_pkg;
  localparam int SEQ_W = 6;

  // a is earlier than b in program order (modulo-2^SEQ_W distance)
  function automatic logic seq_before(input logic [SEQ_W-1:0] a,
                                      input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction
endpackage

// File: rtl/ldst_alias_table.sv
module ldst_alias_table #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rd_idx,
  output logic [1:0]    rd_ctr,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          dec_en,
  input  logic [IW-1:0] dec_idx
);
  logic [DEPTH-1:0][1:0] tbl_q, tbl_nx;

  assign rd_ctr = tbl_q[rd_idx];

  always_comb begin
    tbl_nx = tbl_q;
    if (dec_en && (tbl_q[dec_idx] != 2'd0))
      tbl_nx[dec_idx] = tbl_q[dec_idx] - 2'd1;
    if (set_en)
      tbl_nx[set_idx] = 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else if (set_en || dec_en) tbl_q <= tbl_nx;
  end

  assert_train_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> tbl_q[$past(set_idx)] == 2'd3);
endmodule

// File: rtl/ldst_store_q.sv
module ldst_store_q #(
  parameter int DEPTH = 8,
  parameter int BW    = 29,
  localparam int SW   = ldst_order_pkg::SEQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_v,
  input  logic [SW-1:0] alloc_seq,
  input  logic          res_v,
  input  logic [SW-1:0] res_seq,
  input  logic [BW-1:0] res_blk,
  input  logic          com_v,
  input  logic [SW-1:0] com_seq,
  input  logic [SW-1:0] q_seq,
  input  logic [BW-1:0] q_blk,
  output logic          full,
  output logic          blk_known,
  output logic          unk_older
);
  logic [DEPTH-1:0]         vld_q, vld_nx, av_q, av_nx;
  logic [DEPTH-1:0][SW-1:0] seq_q, seq_nx;
  logic [DEPTH-1:0][BW-1:0] blk_q, blk_nx;
  logic                     free_hit;
  logic [$clog2(DEPTH)-1:0] free_idx;

  assign full = &vld_q;

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!vld_q[i] && !free_hit) begin
        free_hit = 1'b1;
        free_idx = ($clog2(DEPTH))'(i);
      end
  end

  always_comb begin
    blk_known = 1'b0;
    unk_older = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && ldst_order_pkg::seq_before(seq_q[i], q_seq)) begin
        if (!av_q[i]) unk_older = 1'b1;
        else if (blk_q[i] == q_blk) blk_known = 1'b1;
      end
  end

  always_comb begin
    vld_nx = vld_q;
    av_nx  = av_q;
    seq_nx = seq_q;
    blk_nx = blk_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (com_v && vld_q[i] && seq_q[i] == com_seq) vld_nx[i] = 1'b0;
      if (res_v && vld_q[i] && seq_q[i] == res_seq) begin
        av_nx[i]  = 1'b1;
        blk_nx[i] = res_blk;
      end
    end
    if (alloc_v && free_hit) begin
      vld_nx[free_idx] = 1'b1;
      av_nx[free_idx]  = 1'b0;
      seq_nx[free_idx] = alloc_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      av_q  <= '0;
      seq_q <= '0;
      blk_q <= '0;
    end else if (alloc_v || res_v || com_v) begin
      vld_q <= vld_nx;
      av_q  <= av_nx;
      seq_q <= seq_nx;
      blk_q <= blk_nx;
    end
  end

  assert_alloc_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_v && !full && !com_v) |=> $countones(vld_q) == $past($countones(vld_q)) + 1);
endmodule

// File: rtl/ldst_load_track.sv
module ldst_load_track #(
  parameter int DEPTH = 4,
  parameter int BW    = 29,
  parameter int IW    = 4,
  localparam int SW   = ldst_order_pkg::SEQ_W,
  localparam int LW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic [SW-1:0] f_seq,
  input  logic [BW-1:0] f_blk,
  input  logic [IW-1:0] f_idx,
  input  logic          res_v,
  input  logic [SW-1:0] res_seq,
  input  logic [BW-1:0] res_blk,
  input  logic          ret_v,
  input  logic [SW-1:0] ret_seq,
  output logic          full,
  output logic          rp_hit,
  output logic [SW-1:0] rp_seq,
  output logic [IW-1:0] rp_idx,
  output logic          dec_en,
  output logic [IW-1:0] dec_idx
);
  logic [DEPTH-1:0]         vld_q, vld_nx, mt;
  logic [DEPTH-1:0][SW-1:0] seq_q, seq_nx;
  logic [DEPTH-1:0][BW-1:0] blk_q, blk_nx;
  logic [DEPTH-1:0][IW-1:0] idx_q, idx_nx;
  logic [LW-1:0]            best, free_idx;
  logic                     free_hit;

  assign full = &vld_q;

  // conflict scan: younger loads in the resolving store's block, oldest wins
  always_comb begin
    rp_hit = 1'b0;
    best   = '0;
    rp_seq = '0;
    for (int i = 0; i < DEPTH; i++) begin
      mt[i] = res_v && vld_q[i] && (blk_q[i] == res_blk) &&
              ldst_order_pkg::seq_before(res_seq, seq_q[i]);
      if (mt[i] && (!rp_hit || ldst_order_pkg::seq_before(seq_q[i], rp_seq))) begin
        rp_hit = 1'b1;
        best   = LW'(i);
        rp_seq = seq_q[i];
      end
    end
  end
  assign rp_idx = idx_q[best];

  always_comb begin
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (!vld_q[i] && !free_hit) begin
        free_hit = 1'b1;
        free_idx = LW'(i);
      end
  end

  always_comb begin
    vld_nx  = vld_q;
    seq_nx  = seq_q;
    blk_nx  = blk_q;
    idx_nx  = idx_q;
    dec_en  = 1'b0;
    dec_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (ret_v && vld_q[i] && seq_q[i] == ret_seq) begin
        vld_nx[i] = 1'b0;
        dec_en    = 1'b1;
        dec_idx   = idx_q[i];
      end
    if (rp_hit) vld_nx[best] = 1'b0;
    if (fire && free_hit) begin
      vld_nx[free_idx] = 1'b1;
      seq_nx[free_idx] = f_seq;
      blk_nx[free_idx] = f_blk;
      idx_nx[free_idx] = f_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      seq_q <= '0;
      blk_q <= '0;
      idx_q <= '0;
    end else if (fire || ret_v || rp_hit) begin
      vld_q <= vld_nx;
      seq_q <= seq_nx;
      blk_q <= blk_nx;
      idx_q <= idx_nx;
    end
  end

  assert_no_fire_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> !full);
endmodule

// File: rtl/ldst_order_unit.sv
module ldst_order_unit #(
  parameter int AW         = 32,
  parameter int PC_W       = 32,
  parameter int SQ_DEPTH   = 8,
  parameter int LQ_DEPTH   = 4,
  parameter int PRED_DEPTH = 16,
  parameter int GRAIN      = 8,
  parameter int PENALTY    = 20,
  localparam int SW   = ldst_order_pkg::SEQ_W,
  localparam int OW   = $clog2(GRAIN),
  localparam int BW   = AW - OW,
  localparam int IW   = $clog2(PRED_DEPTH),
  localparam int CW   = $clog2(PENALTY + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_alloc_v,
  input  logic [SW-1:0]   st_alloc_seq,
  output logic            sq_full,
  input  logic            st_res_v,
  input  logic [SW-1:0]   st_res_seq,
  input  logic [AW-1:0]   st_res_addr,
  input  logic            st_commit_v,
  input  logic [SW-1:0]   st_commit_seq,
  input  logic            ld_req_v,
  input  logic [SW-1:0]   ld_req_seq,
  input  logic [PC_W-1:0] ld_req_pc,
  input  logic [AW-1:0]   ld_req_addr,
  output logic            ld_grant,
  input  logic            ld_retire_v,
  input  logic [SW-1:0]   ld_retire_seq,
  output logic            replay_v,
  output logic [SW-1:0]   replay_seq,
  output logic            stall
);
  logic [1:0]    ctr;
  logic          blk_known, unk_older, lq_full;
  logic          rp_hit, dec_en;
  logic [SW-1:0] rp_seq;
  logic [IW-1:0] rp_idx, dec_idx, pidx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          rp_v_q;
  logic [SW-1:0] rp_seq_q;
  logic          unused_bits;

  assign pidx        = ld_req_pc[IW-1:0];
  assign unused_bits = ^{ld_req_pc[PC_W-1:IW], ld_req_addr[OW-1:0], st_res_addr[OW-1:0]};

  ldst_alias_table #(.DEPTH(PRED_DEPTH)) u_pred (
    .clk(clk), .rst_n(rst_n), .rd_idx(pidx), .rd_ctr(ctr),
    .set_en(rp_hit), .set_idx(rp_idx), .dec_en(dec_en), .dec_idx(dec_idx));

  ldst_store_q #(.DEPTH(SQ_DEPTH), .BW(BW)) u_sq (
    .clk(clk), .rst_n(rst_n),
    .alloc_v(st_alloc_v), .alloc_seq(st_alloc_seq),
    .res_v(st_res_v), .res_seq(st_res_seq), .res_blk(st_res_addr[AW-1:OW]),
    .com_v(st_commit_v), .com_seq(st_commit_seq),
    .q_seq(ld_req_seq), .q_blk(ld_req_addr[AW-1:OW]),
    .full(sq_full), .blk_known(blk_known), .unk_older(unk_older));

  assign stall    = (cnt_q != '0);
  assign ld_grant = ld_req_v && !stall && !st_res_v && !lq_full && !blk_known &&
                    (!unk_older || !ctr[1]);

  ldst_load_track #(.DEPTH(LQ_DEPTH), .BW(BW), .IW(IW)) u_lq (
    .clk(clk), .rst_n(rst_n),
    .fire(ld_grant), .f_seq(ld_req_seq), .f_blk(ld_req_addr[AW-1:OW]), .f_idx(pidx),
    .res_v(st_res_v), .res_seq(st_res_seq), .res_blk(st_res_addr[AW-1:OW]),
    .ret_v(ld_retire_v), .ret_seq(ld_retire_seq),
    .full(lq_full), .rp_hit(rp_hit), .rp_seq(rp_seq), .rp_idx(rp_idx),
    .dec_en(dec_en), .dec_idx(dec_idx));

  always_comb begin
    cnt_nx = cnt_q;
    if (rp_hit) cnt_nx = CW'(PENALTY);
    else if (cnt_q != '0) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rp_v_q   <= 1'b0;
      rp_seq_q <= '0;
    end else begin
      if (rp_hit || stall) cnt_q <= cnt_nx;
      rp_v_q <= rp_hit;
      if (rp_hit) rp_seq_q <= rp_seq;
    end
  end

  assign replay_v   = rp_v_q;
  assign replay_seq = rp_seq_q;

  assert_replay_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    replay_v |-> stall);
  assert_penalty_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rp_hit) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_replay_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (replay_v && !rp_hit) |=> !replay_v);
endmodule

// File: tb/sim_ldst_order_unit.sv
`timescale 1ns/1ps
module sim_ldst_order_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_alloc_v = 0, st_res_v = 0, st_commit_v = 0, ld_req_v = 0, ld_retire_v = 0;
  logic [5:0]  st_alloc_seq = 0, st_res_seq = 0, st_commit_seq = 0, ld_req_seq = 0, ld_retire_seq = 0;
  logic [31:0] st_res_addr = 0, ld_req_pc = 0, ld_req_addr = 0;
  logic        sq_full, ld_grant, replay_v, stall;
  logic [5:0]  replay_seq;
  int total = 0, bad = 0, n = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ldst_order_unit u0 (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic alloc(input int s);
    st_alloc_v = 1; st_alloc_seq = 6'(s); tick(); st_alloc_v = 0;
  endtask
  task automatic resolve(input int s, input int a);
    st_res_v = 1; st_res_seq = 6'(s); st_res_addr = 32'(a); tick(); st_res_v = 0;
  endtask
  task automatic commit(input int s);
    st_commit_v = 1; st_commit_seq = 6'(s); tick(); st_commit_v = 0;
  endtask
  task automatic retire(input int s);
    ld_retire_v = 1; ld_retire_seq = 6'(s); tick(); ld_retire_v = 0;
  endtask
  task automatic req(input int s, input int pc, input int a, input bit exp, input string rq);
    ld_req_v = 1; ld_req_seq = 6'(s); ld_req_pc = 32'(pc); ld_req_addr = 32'(a);
    #1 chk(ld_grant == exp, rq, ld_grant, exp);
    tick(); ld_req_v = 0;
  endtask
  task automatic expect_replay(input int s, input string rq);
    chk(replay_v == 1, rq, replay_v, 1);
    chk(replay_seq == 6'(s), rq, replay_seq, s);
  endtask
  task automatic count_stall(output int c);
    c = 0;
    while (stall && c < 100) begin c++; @(negedge clk); end
  endtask

  // R1 reset state
  task automatic t_reset();
    chk(!stall && !replay_v && !sq_full, "R1", {stall, replay_v, sq_full}, 0);
    req(0, 0, 32'h40, 1, "R1");
    retire(0);
  endtask

  // R2 known older store, same block vs different block
  task automatic t_known();
    alloc(1); resolve(1, 32'h100);
    req(2, 0, 32'h104, 0, "R2");
    req(2, 0, 32'h108, 1, "R2");
    retire(2); commit(1);
  endtask

  // R4 younger unresolved store does not hold back or replay the load
  task automatic t_younger();
    alloc(5);
    req(4, 1, 32'h200, 1, "R4");
    resolve(5, 32'h200);
    chk(replay_v == 0 && stall == 0, "R4", replay_v, 0);
    retire(4); commit(5);
  endtask

  // R3 bypass, R5 replay, R7 stall window
  task automatic t_bypass_conflict();
    alloc(10);
    req(11, 3, 32'h300, 1, "R3");
    resolve(10, 32'h304);
    expect_replay(11, "R5");
    chk(stall == 1, "R7", stall, 1);
    n = 1;
    req(12, 5, 32'h500, 0, "R7");
    chk(replay_v == 0, "R5", replay_v, 0);
    begin int c; count_stall(c); n += c; end
    chk(n == 20, "R7", n, 20);
  endtask

  // R8 training to 3, then decay on clean retires
  task automatic t_train();
    alloc(20);
    req(21, 3, 32'h900, 0, "R3");
    resolve(20, 32'h700);
    req(21, 3, 32'h900, 1, "R8");
    retire(21);                 // counter 3 -> 2
    alloc(30);
    req(31, 3, 32'hA00, 0, "R8");
    resolve(30, 32'hB00);
    req(31, 3, 32'hA00, 1, "R8");
    retire(31);                 // counter 2 -> 1
    alloc(40);
    req(41, 3, 32'hC00, 1, "R8");
    retire(41);
    resolve(40, 32'hD00);
    chk(replay_v == 0, "R8", replay_v, 0);
    commit(10); commit(20); commit(30); commit(40);
  endtask

  // R6 oldest of several conflicting loads
  task automatic t_oldest();
    int c;
    alloc(50);
    req(53, 7, 32'h604, 1, "R6");
    req(51, 6, 32'h600, 1, "R6");
    req(52, 8, 32'h700, 1, "R6");
    resolve(50, 32'h600);
    expect_replay(51, "R6");
    count_stall(c);
    retire(52); retire(53); commit(50);
  endtask

  // R10 same-cycle resolve and full load tracker
  task automatic t_withhold();
    ld_req_v = 1; ld_req_seq = 6'd60; ld_req_pc = 32'd11; ld_req_addr = 32'h1000;
    st_res_v = 1; st_res_seq = 6'd33; st_res_addr = 32'h2000;
    #1 chk(ld_grant == 0, "R10", ld_grant, 0);
    tick(); ld_req_v = 0; st_res_v = 0;
    for (int i = 0; i < 4; i++) req(60 + i, 11, 32'h1000 + 16 * i, 1, "R10");
    req(0, 11, 32'h1100, 0, "R10");
    for (int i = 0; i < 4; i++) retire(60 + i);
  endtask

  // R9 store queue capacity and dropped allocation
  task automatic t_capacity();
    for (int i = 0; i < 8; i++) begin
      chk(sq_full == 0, "R9", sq_full, 0);
      alloc(2 + i);
    end
    chk(sq_full == 1, "R9", sq_full, 1);
    alloc(10);                  // dropped
    for (int i = 0; i < 8; i++) resolve(2 + i, 32'hF00);
    commit(2);
    chk(sq_full == 0, "R9", sq_full, 0);
    for (int i = 1; i < 8; i++) commit(2 + i);
    req(11, 6, 32'h100, 1, "R9");   // counter for pc 6 is 3
    retire(11);
  endtask

  // R11 sequence wrap
  task automatic t_wrap();
    int c;
    alloc(62);
    req(1, 9, 32'h40, 1, "R11");
    resolve(62, 32'h44);
    expect_replay(1, "R11");
    count_stall(c);
    commit(62);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_known();
    t_younger();
    t_bypass_conflict();
    t_train();
    t_oldest();
    t_withhold();
    t_capacity();
    t_wrap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule